// File: doc/BRIEF.md
# Serial Interrupt Status Controller

This block collects the six event pulses of a serial port into a status register and drives a single interrupt line from them. Each event sets its status bit whether or not it is enabled. A separate control word holds one enable bit per event, at the same bit position as the status bit it gates. The interrupt is high whenever any status bit is set together with its enable. Software clears a status bit by writing 1 to it.

The control word also holds two special bits. The receive-trigger gate decides whether receive-trigger events are recorded at all. The software-reset bit holds the serial port in reset. While that bit is set, all status bits are forced to zero and no event is recorded, but the enables keep their values.

Access is through a plain register port. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. The software reset is a two-state machine:
- `ST_RUN` moves to `ST_HOLD` on transition `T_ENTER`, which is a control write with bit 28 set.
- `ST_HOLD` returns to `ST_RUN` on transition `T_RELEASE`, which is a control write with bit 28 clear.
- Every other cycle stays in the current state.

Top module: `sisc_top`

## Requirements
- R1: After `rst_n` is released, the control word and the status word both read 0, `irq` is low and `soft_rst` is low.
- R2: The control word is at address 0 and the status word at address 1. The enable bits sit at these positions: 13 underrun, 12 overflow, 9 transmit end, 8 transfer end, 4 transmit-FIFO-empty trigger, 0 receive trigger. Bit 19 is the receive-trigger gate and bit 28 is the software reset. All other bits read 0.
- R3: `evt[5:0]` carries, in index order: receive trigger, transmit-FIFO-empty trigger, transfer end, transmit end, overflow, underrun. A high pulse at a clock edge sets the matching status bit, at the same position as its enable, whatever the enable holds.
- R4: A write to address 1 clears each status bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: When an event and a clearing write for the same bit fall on the same edge, the bit ends up set.
- R6: `irq` is high exactly when some status bit and its enable are both 1. It follows register changes in the same cycle.
- R7: While the receive-trigger gate is 0, `evt[0]` is ignored. A gate write on the same edge as the event does not affect that event; the old gate value applies.
- R8: A control write with bit 28 set (`T_ENTER`) zeroes all status bits on that edge. From then until and including the edge of the releasing write (`T_RELEASE`), status stays 0 and events are ignored. Enables and gate are written and kept as usual. `soft_rst` is high in `ST_HOLD`.
- R9: Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| evt | input | 6 | Event pulses |
| irq | output | 1 | Interrupt line |
| soft_rst | output | 1 | Software-reset hold for the serial port |

## Verification
Timing of each result:
- A write or event is sampled on one rising edge, and the resulting status, control and `soft_rst` values are readable after that same edge.
- `irq` is combinational from those registers, so it is due in the cycle after that edge with no extra delay.

The bench drives inputs on the falling edge and advances one rising edge per step. It compares against its model at the next falling edge, stepping `addr` through both registers in that low phase without another edge. Same-edge corner cases (event against clear, gate write against event, reset entry against event) are checked on that following falling edge.

// File: rtl/sisc_pkg.sv
`timescale 1ns/1ps
package sisc_pkg;
    localparam int unsigned N_EVT    = 6;
    localparam int unsigned CTRL_ADR = 0;
    localparam int unsigned STAT_ADR = 1;
    localparam int unsigned RST_BIT  = 28;
    localparam int unsigned GATE_BIT = 19;
    localparam int unsigned RX_IDX   = 0;
    // event index -> bit position in both words
    localparam int unsigned EVT_POS [N_EVT] = '{0, 4, 8, 9, 12, 13};

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } sisc_state_e;
endpackage

// File: rtl/sisc_ctrl_fsm.sv
`timescale 1ns/1ps
module sisc_ctrl_fsm
    import sisc_pkg::*;
#(
    parameter int unsigned NE = N_EVT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [NE-1:0] wr_en_bits,
    input  logic          wr_gate,
    input  logic          wr_rst,
    output logic [NE-1:0] en_q,
    output logic          gate_q,
    output logic          hold_now,
    output logic          soft_rst
);
    sisc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions: T_ENTER, T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (ctrl_wr && wr_rst)  state_d = ST_HOLD;
            ST_HOLD: if (ctrl_wr && !wr_rst) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        soft_rst = 1'b0;
        hold_now = ctrl_wr && wr_rst;
        unique case (state_q)
            ST_RUN:  ;
            ST_HOLD: begin
                soft_rst = 1'b1;
                hold_now = 1'b1;
            end
            default: ;
        endcase
    end

    // enables and gate are kept across the software reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            gate_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= wr_en_bits;
            gate_q <= wr_gate;
        end
    end
endmodule

// File: rtl/sisc_status_bank.sv
`timescale 1ns/1ps
module sisc_status_bank
    import sisc_pkg::*;
#(
    parameter int unsigned NE = N_EVT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] evt,
    input  logic [NE-1:0] clr_bits,
    input  logic          gate_q,
    input  logic          hold_now,
    output logic [NE-1:0] stat_q
);
    for (genvar i = 0; i < NE; i++) begin : g_bit
        logic set_i;
        if (i == RX_IDX) begin : g_gated
            assign set_i = evt[i] && gate_q;
        end else begin : g_plain
            assign set_i = evt[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           stat_q[i] <= 1'b0;
            else if (hold_now)    stat_q[i] <= 1'b0;
            else if (set_i)       stat_q[i] <= 1'b1;
            else if (clr_bits[i]) stat_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sisc_regmap.sv
`timescale 1ns/1ps
module sisc_regmap
    import sisc_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 2,
    parameter int unsigned NE = N_EVT
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NE-1:0] en_q,
    input  logic          gate_q,
    input  logic          soft_rst,
    input  logic [NE-1:0] stat_q,
    output logic          ctrl_wr,
    output logic [NE-1:0] clr_bits,
    output logic [NE-1:0] wr_en_bits,
    output logic          wr_gate,
    output logic          wr_rst,
    output logic [DW-1:0] ctrl_word,
    output logic [DW-1:0] stat_word,
    output logic [DW-1:0] rdata
);
    logic sel_ctrl, sel_stat;
    logic [NE-1:0] w_field;

    assign sel_ctrl = (addr == AW'(CTRL_ADR));
    assign sel_stat = (addr == AW'(STAT_ADR));
    assign ctrl_wr  = wr_en && sel_ctrl;

    always_comb begin
        for (int i = 0; i < int'(NE); i++) w_field[i] = wdata[EVT_POS[i]];
    end

    assign wr_en_bits = w_field;
    assign clr_bits   = (wr_en && sel_stat) ? w_field : '0;
    assign wr_gate    = wdata[GATE_BIT];
    assign wr_rst     = wdata[RST_BIT];

    always_comb begin
        ctrl_word = '0;
        stat_word = '0;
        for (int i = 0; i < int'(NE); i++) begin
            ctrl_word[EVT_POS[i]] = en_q[i];
            stat_word[EVT_POS[i]] = stat_q[i];
        end
        ctrl_word[GATE_BIT] = gate_q;
        ctrl_word[RST_BIT]  = soft_rst;
    end

    always_comb begin
        if (sel_ctrl)      rdata = ctrl_word;
        else if (sel_stat) rdata = stat_word;
        else               rdata = '0;
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;
endmodule

// File: rtl/sisc_top.sv
`timescale 1ns/1ps
module sisc_top
    import sisc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_EVT-1:0]  evt,
    output logic              irq,
    output logic              soft_rst
);
    localparam int unsigned NE = N_EVT;

    logic          ctrl_wr, wr_gate, wr_rst, gate_q, hold_now;
    logic [NE-1:0] clr_bits, wr_en_bits, en_q, stat_q;
    logic [DATA_W-1:0] ctrl_word, stat_word;

    sisc_regmap #(.DW(DATA_W), .AW(ADDR_W), .NE(NE)) u_map (
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .en_q(en_q), .gate_q(gate_q), .soft_rst(soft_rst), .stat_q(stat_q),
        .ctrl_wr(ctrl_wr), .clr_bits(clr_bits), .wr_en_bits(wr_en_bits),
        .wr_gate(wr_gate), .wr_rst(wr_rst),
        .ctrl_word(ctrl_word), .stat_word(stat_word), .rdata(rdata)
    );

    sisc_ctrl_fsm #(.NE(NE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .wr_en_bits(wr_en_bits), .wr_gate(wr_gate), .wr_rst(wr_rst),
        .en_q(en_q), .gate_q(gate_q), .hold_now(hold_now), .soft_rst(soft_rst)
    );

    sisc_status_bank #(.NE(NE)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr_bits(clr_bits),
        .gate_q(gate_q), .hold_now(hold_now), .stat_q(stat_q)
    );

    assign irq = |(stat_q & en_q);
endmodule

// File: rtl/sisc_checker.sv
`timescale 1ns/1ps
module sisc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [31:0] wdata,
    input logic [5:0]  evt,
    input logic        irq,
    input logic [31:0] ctrl_word,
    input logic [31:0] stat_word
);
    logic hold_c;
    assign hold_c = ctrl_word[28] || (wr_en && addr == 2'd0 && wdata[28]);

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[5] && !hold_c) |=> stat_word[13]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wdata[9] && !evt[3]) |=> !stat_word[9]);

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[4] && wr_en && addr == 2'd1 && wdata[12] && !hold_c) |=> stat_word[12]);

    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word == 32'd0) |-> !irq);

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[19] && !stat_word[0]) |=> !stat_word[0]);

    assert_hold_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[28] |-> (stat_word == 32'd0));

    logic unused_chk;
    assign unused_chk = ^{wdata, stat_word, ctrl_word};
endmodule

bind sisc_top sisc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .evt(evt), .irq(irq), .ctrl_word(ctrl_word), .stat_word(stat_word)
);

// File: tb/tb_sisc_top.sv
`timescale 1ns/100ps
module tb_sisc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [5:0]  evt = 6'd0;
    logic        irq, soft_rst;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    // model state
    logic [5:0] m_en = '0, m_stat = '0;
    logic       m_gate = 1'b0, m_hold = 1'b0;

    always #2 clk = ~clk;

    sisc_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq), .soft_rst(soft_rst));

    function automatic int pos(int i);
        case (i)
            0: return 0;   1: return 4;   2: return 8;
            3: return 9;   4: return 12;  default: return 13;
        endcase
    endfunction

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] w = '0;
        for (int i = 0; i < 6; i++) w[pos(i)] = m_en[i];
        w[19] = m_gate;
        w[28] = m_hold;
        return w;
    endfunction

    function automatic logic [31:0] exp_stat();
        logic [31:0] w = '0;
        for (int i = 0; i < 6; i++) w[pos(i)] = m_stat[i];
        return w;
    endfunction

    task automatic model(bit w, logic [1:0] a, logic [31:0] d, logic [5:0] e);
        bit hold = m_hold || (w && a == 2'd0 && d[28]);
        for (int i = 0; i < 6; i++) begin
            bit s = e[i] && (i != 0 || m_gate);
            bit c = w && a == 2'd1 && d[pos(i)];
            if (hold)   m_stat[i] = 1'b0;
            else if (s) m_stat[i] = 1'b1;
            else if (c) m_stat[i] = 1'b0;
        end
        if (w && a == 2'd0) begin
            for (int i = 0; i < 6; i++) m_en[i] = d[pos(i)];
            m_gate = d[19];
            m_hold = d[28];
        end
    endtask

    task automatic cmp(logic [31:0] got, logic [31:0] exp, string tag);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(bit w, logic [1:0] a, logic [31:0] d, logic [5:0] e);
        wr_en = w; addr = a; wdata = d; evt = e;
        model(w, a, d, e);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic check_all(string tc, string ts, string ti);
        addr = 2'd0; #0.4;
        cmp(rdata, exp_ctrl(), tc);
        addr = 2'd1; #0.4;
        cmp(rdata, exp_stat(), ts);
        cmp({31'd0, irq}, {31'd0, (|(m_stat & m_en))}, ti);
        cmp({31'd0, soft_rst}, {31'd0, m_hold}, "R8 soft_rst");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++; errs++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 ctrl", "R1 stat", "R1 irq");

        // R3: all events, nothing enabled; rx gate is 0 so evt[0] ignored (R7)
        step(1'b0, 2'd0, 0, 6'b111111);
        check_all("R2 ctrl", "R3/R7 stat", "R6 irq off");
        // R6: enable transfer end only -> irq
        step(1'b1, 2'd0, 32'h0000_0100, 6'd0);
        check_all("R2 ctrl", "R3 stat", "R6 irq on");
        // R4: write 0 keeps, write 1 clears bit 8
        step(1'b1, 2'd1, 32'h0000_0000, 6'd0);
        check_all("R2 ctrl", "R4 keep", "R6 irq");
        step(1'b1, 2'd1, 32'h0000_0100, 6'd0);
        check_all("R2 ctrl", "R4 clear", "R6 irq clr");
        // R5: event and clear for overflow on same edge
        step(1'b1, 2'd1, 32'h0000_1000, 6'b010000);
        check_all("R2 ctrl", "R5 event wins", "R6 irq");
        // R7: gate written same edge as rx event -> ignored, then counts
        step(1'b1, 2'd0, 32'h0008_0001, 6'b000001);
        check_all("R2 gate", "R7 same-edge", "R6 irq");
        step(1'b0, 2'd0, 0, 6'b000001);
        check_all("R2 gate", "R7 gated on", "R6 irq rx");
        // R9: unused address
        step(1'b1, 2'd2, 32'hFFFF_FFFF, 6'd0);
        check_all("R9 ctrl", "R9 stat", "R9 irq");
        addr = 2'd3; #0.4; cmp(rdata, 32'd0, "R9 read3");
        // R8: enter reset with events on same edge
        step(1'b1, 2'd0, 32'h1008_3301, 6'b111111);
        check_all("R8 enables kept", "R8 cleared", "R8 irq");
        step(1'b0, 2'd0, 0, 6'b111111);
        check_all("R8 ctrl", "R8 ignored", "R8 irq");
        step(1'b1, 2'd0, 32'h0008_3301, 6'b100000);
        check_all("R8 release", "R8 release edge", "R8 irq");
        step(1'b0, 2'd0, 0, 6'b100000);
        check_all("R8 ctrl", "R3 after release", "R6 irq");

        // constrained random
        for (int n = 0; n < 600; n++) begin
            bit w = ($urandom % 3) == 0;
            logic [1:0] a = 2'($urandom % 4);
            logic [31:0] d = $urandom;
            logic [5:0] e = 6'($urandom) & 6'($urandom);
            if (a == 2'd0 && ($urandom % 6) != 0) d[28] = 1'b0;
            step(w, a, d, e);
            check_all("R2 rnd", "R3 rnd", "R6 rnd");
        end
        finish_run();
    end
endmodule